// File: doc/BRIEF.md
# Open-Load Fault Filter and Recovery Controller

This block sits between the analog sensing of a multi-channel LED current driver and its output stage. It receives one raw open-load indication per channel and a set of raw global conditions: supply undervoltage, thermal warning, thermal shutdown, a short on the current-setting resistor, and the sensed level of an open-drain diagnostic pin. Open-load, current-set short and external pin forcing pass through a persistence filter that counts a 1 MHz tick enable. A flag changes only after the raw level has differed from it for ten consecutive ticks, which is 10 µs.

The filtered flags select what happens to the outputs. A diagnostic mode chosen by two control bits (auto-recovery, detect-only) sets whether the open-drain pin is pulled low for open-load and whether channels are reshaped. The block then drives the pin, issues a per-channel off or low-current command and can request low-power mode. A diagnostic-enable input shows whether the string voltage is high enough for open-load sensing to be trusted. It gates that sensing and the handling of an externally forced pin.

Top module: `diag_fault_ctrl`

## Requirements
- R1: A raw open-load, current-set-short or external-pin condition sets its flag on the 10th consecutive `tick_1us` pulse at which it is present, and not before.
- R2: A set flag clears on the 10th consecutive tick at which its raw condition is absent. Any reversal of the raw level before then restarts the count from zero.
- R3: While `diag_en` is low, per-channel open-load flags neither set nor clear: faults already latched are kept.
- R4: The mode code {`mode_ar`,`mode_do`} is taken on each clock: 2'b10 selects auto-recovery, 2'b01 selects detect-only, 2'b00 selects off, and 2'b11 keeps the mode last applied. The mode after reset is off.
- R5: In off mode, open-load raw inputs are treated as absent, and no open-load fault pulls the diagnostic pin.
- R6: In detect-only mode an open-load fault pulls the pin low (`diag_pull`=1) while `ch_off` and `ch_low` stay zero. An externally forced pin has no effect on `ch_off`, `ch_low` or `lp_req`.
- R7: In auto-recovery mode, with open-load faults present, `ch_low` equals the fault vector, `ch_off` is its complement and `diag_pull` is 1. After the faults clear, all three return to 0.
- R8: In auto-recovery mode with `diag_en` high, a filtered external pin fault sets `ch_off` to all ones and `lp_req` to 1. The block's own pull-down is never counted as external forcing. `st_diagerr` reports the filtered external fault.
- R9: A filtered current-set short turns every channel off and pulls the pin. A thermal-shutdown flag also pulls the pin.
- R10: `st_uv` follows `uv_raw` one clock later, and while it is set every channel is off.
- R11: `st_tw` and `st_tsd` set one clock after their raw input rises. They clear only on a clock where `status_rd` is high and the raw input is low.
- R12: `st_ol` is 1 exactly when at least one bit of `fault_ch` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1us | input | 1 | 1 MHz tick enable for the persistence filters |
| diag_en | input | 1 | Diagnostic enable (string voltage adequate) |
| mode_ar | input | 1 | Mode code bit: auto-recovery |
| mode_do | input | 1 | Mode code bit: detect-only |
| ol_raw | input | NCH | Raw per-channel open-load detect |
| iset_short | input | 1 | Raw current-set resistor short |
| diag_pin_low | input | 1 | Sensed low level on the diagnostic pin |
| uv_raw | input | 1 | Raw supply undervoltage |
| tw_raw | input | 1 | Raw thermal warning |
| tsd_raw | input | 1 | Raw thermal shutdown |
| status_rd | input | 1 | Status read strobe |
| st_ol | output | 1 | Any channel in open-load |
| st_iset | output | 1 | Filtered current-set short |
| st_diagerr | output | 1 | Filtered external pin forcing |
| st_uv | output | 1 | Undervoltage flag |
| st_tw | output | 1 | Sticky thermal warning |
| st_tsd | output | 1 | Sticky thermal shutdown |
| fault_ch | output | NCH | Filtered per-channel open-load flags |
| diag_pull | output | 1 | Open-drain pull-down enable (pin low) |
| ch_off | output | NCH | Per-channel switch-off command |
| ch_low | output | NCH | Per-channel low-current command |
| lp_req | output | 1 | Low-power mode request |

## Verification
A table of open-load patterns is run through every mode: a single channel, scattered channels, all channels with diagnostics off, all channels with enable low, and channels at both ends of the vector in auto-recovery. Together they separate the mode decode, the enable gating and the mapping of the low-current and off vectors per channel. Directed runs check the filter edge at 9 and 10 ticks in both directions, and show that a one-cycle reversal restarts the count. They also cover the 11 mode code after each of two different modes and the difference between a pin pulled low by the block itself and one forced externally. The remaining checks cover the priority of undervoltage and current-set short over all modes and the read-to-clear rule of the thermal flags while the condition is still present.

// File: rtl/diagctl_pkg.sv
package diagctl_pkg;

  typedef enum logic [1:0] {
    DM_OFF  = 2'b00,
    DM_DET  = 2'b01,
    DM_AUTO = 2'b10
  } dmode_t;

  localparam int unsigned FILT_TICKS = 10;

endpackage

// File: rtl/persist_filter.sv
module persist_filter #(
  parameter int unsigned CNT_LEN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hold,
  input  logic raw,
  output logic flag
);
  localparam int unsigned CW = $clog2(CNT_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(CNT_LEN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (hold || (raw == flag_q)) begin
      cnt_d = '0;
    end else if (tick) begin
      if (cnt_q == LAST) begin
        flag_d = raw;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic rd,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (raw)     flag_d = 1'b1;
    else if (rd) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/diag_out_ctrl.sv
module diag_out_ctrl
  import diagctl_pkg::*;
#(
  parameter int unsigned NCH = 12
) (
  input  dmode_t         mode,
  input  logic [NCH-1:0] fault_ch,
  input  logic           ext_f,
  input  logic           diag_en,
  input  logic           uv,
  input  logic           isc,
  input  logic           tsd,
  output logic [NCH-1:0] ch_off,
  output logic [NCH-1:0] ch_low,
  output logic           lp_req,
  output logic           diag_pull
);
  logic ol_any;
  logic ol_active;

  assign ol_any    = |fault_ch;
  assign ol_active = (mode != DM_OFF) && ol_any;

  always_comb begin
    ch_off    = '0;
    ch_low    = '0;
    lp_req    = 1'b0;
    diag_pull = isc || tsd || ol_active;
    if (uv || isc) begin
      ch_off = '1;
    end else if ((mode == DM_AUTO) && ext_f && diag_en) begin
      ch_off = '1;
      lp_req = 1'b1;
    end else if ((mode == DM_AUTO) && ol_any) begin
      ch_low = fault_ch;
      ch_off = ~fault_ch;
    end
  end
endmodule

// File: rtl/diag_fault_ctrl.sv
module diag_fault_ctrl
  import diagctl_pkg::*;
#(
  parameter int unsigned NCH      = 12,
  parameter int unsigned FILT_LEN = FILT_TICKS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_1us,
  input  logic           diag_en,
  input  logic           mode_ar,
  input  logic           mode_do,
  input  logic [NCH-1:0] ol_raw,
  input  logic           iset_short,
  input  logic           diag_pin_low,
  input  logic           uv_raw,
  input  logic           tw_raw,
  input  logic           tsd_raw,
  input  logic           status_rd,
  output logic           st_ol,
  output logic           st_iset,
  output logic           st_diagerr,
  output logic           st_uv,
  output logic           st_tw,
  output logic           st_tsd,
  output logic [NCH-1:0] fault_ch,
  output logic           diag_pull,
  output logic [NCH-1:0] ch_off,
  output logic [NCH-1:0] ch_low,
  output logic           lp_req
);
  dmode_t mode_q, mode_d;
  logic   uv_q;
  logic   ext_raw;
  logic   ol_gate;

  // mode decode; code 11 retains the applied mode
  always_comb begin
    unique case ({mode_ar, mode_do})
      2'b10:   mode_d = DM_AUTO;
      2'b01:   mode_d = DM_DET;
      2'b00:   mode_d = DM_OFF;
      default: mode_d = mode_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= DM_OFF;
      uv_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      uv_q   <= uv_raw;
    end
  end

  assign ol_gate = (mode_q != DM_OFF);

  for (genvar i = 0; i < NCH; i++) begin : g_ol
    persist_filter #(.CNT_LEN(FILT_LEN)) u_olf (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick_1us),
      .hold (~diag_en),
      .raw  (ol_raw[i] & ol_gate),
      .flag (fault_ch[i])
    );
  end

  persist_filter #(.CNT_LEN(FILT_LEN)) u_iscf (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_1us),
    .hold (1'b0),
    .raw  (iset_short),
    .flag (st_iset)
  );

  // pin low not caused by own pull-down counts as external forcing
  assign ext_raw = diag_pin_low & ~diag_pull & diag_en;

  persist_filter #(.CNT_LEN(FILT_LEN)) u_extf (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick_1us),
    .hold (1'b0),
    .raw  (ext_raw),
    .flag (st_diagerr)
  );

  sticky_flag u_tw (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (tw_raw),
    .rd   (status_rd),
    .flag (st_tw)
  );

  sticky_flag u_tsd (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (tsd_raw),
    .rd   (status_rd),
    .flag (st_tsd)
  );

  diag_out_ctrl #(.NCH(NCH)) u_out (
    .mode     (mode_q),
    .fault_ch (fault_ch),
    .ext_f    (st_diagerr),
    .diag_en  (diag_en),
    .uv       (uv_q),
    .isc      (st_iset),
    .tsd      (st_tsd),
    .ch_off   (ch_off),
    .ch_low   (ch_low),
    .lp_req   (lp_req),
    .diag_pull(diag_pull)
  );

  assign st_uv = uv_q;
  assign st_ol = |fault_ch;
endmodule

// File: rtl/diag_fault_ctrl_chk.sv
module diag_fault_ctrl_chk
  import diagctl_pkg::*;
#(
  parameter int unsigned NCH = 12
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick_1us,
  input logic           diag_en,
  input dmode_t         mode_q,
  input logic           st_uv,
  input logic           st_iset,
  input logic           st_tsd,
  input logic [NCH-1:0] fault_ch,
  input logic           diag_pull,
  input logic [NCH-1:0] ch_off,
  input logic [NCH-1:0] ch_low,
  input logic           lp_req
);
  // R1
  filter_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_1us |=> $stable(fault_ch));

  // R3
  enable_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !diag_en |=> $stable(fault_ch));

  // R6
  detect_no_touch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == DM_DET && !st_uv && !st_iset) |-> (ch_off == '0 && ch_low == '0 && !lp_req));

  // R7
  low_off_disjoint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_low & ch_off) == '0);

  // R8
  lowpower_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lp_req |-> (&ch_off));

  // R9
  iset_short_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_iset |-> ((&ch_off) && diag_pull));

  // R9
  tsd_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_tsd |-> diag_pull);

  // R10
  uv_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_uv |-> (&ch_off));
endmodule

bind diag_fault_ctrl diag_fault_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_1us (tick_1us),
  .diag_en  (diag_en),
  .mode_q   (mode_q),
  .st_uv    (st_uv),
  .st_iset  (st_iset),
  .st_tsd   (st_tsd),
  .fault_ch (fault_ch),
  .diag_pull(diag_pull),
  .ch_off   (ch_off),
  .ch_low   (ch_low),
  .lp_req   (lp_req)
);

// File: tb/tb_diag_fault_ctrl.sv
`timescale 1ns/1ps
module tb_diag_fault_ctrl;
  localparam int NCH = 12;
  localparam int NV  = 5;
  // {ar, do, en, ol, exp_fault, exp_off, exp_low, exp_pull}
  localparam logic [51:0] VEC [NV] = '{
    {2'b10, 1'b1, 12'h001, 12'h001, 12'hFFE, 12'h001, 1'b1},
    {2'b01, 1'b1, 12'h0A0, 12'h0A0, 12'h000, 12'h000, 1'b1},
    {2'b00, 1'b1, 12'hFFF, 12'h000, 12'h000, 12'h000, 1'b0},
    {2'b10, 1'b0, 12'hFFF, 12'h000, 12'h000, 12'h000, 1'b0},
    {2'b10, 1'b1, 12'h803, 12'h803, 12'h7FC, 12'h803, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n, tick, diag_en, mode_ar, mode_do;
  logic [NCH-1:0] ol_raw;
  logic iset_short, ext_force, uv_raw, tw_raw, tsd_raw, status_rd;
  logic diag_pin_low;
  logic st_ol, st_iset, st_diagerr, st_uv, st_tw, st_tsd, diag_pull, lp_req;
  logic [NCH-1:0] fault_ch, ch_off, ch_low;
  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  assign diag_pin_low = diag_pull | ext_force;

  diag_fault_ctrl #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick), .diag_en(diag_en),
    .mode_ar(mode_ar), .mode_do(mode_do), .ol_raw(ol_raw),
    .iset_short(iset_short), .diag_pin_low(diag_pin_low), .uv_raw(uv_raw),
    .tw_raw(tw_raw), .tsd_raw(tsd_raw), .status_rd(status_rd),
    .st_ol(st_ol), .st_iset(st_iset), .st_diagerr(st_diagerr), .st_uv(st_uv),
    .st_tw(st_tw), .st_tsd(st_tsd), .fault_ch(fault_ch), .diag_pull(diag_pull),
    .ch_off(ch_off), .ch_low(ch_low), .lp_req(lp_req)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tk(int n);
    repeat (n) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 0; diag_en = 0; mode_ar = 0; mode_do = 0; ol_raw = '0;
    iset_short = 0; ext_force = 0; uv_raw = 0; tw_raw = 0; tsd_raw = 0; status_rd = 0;
    step(2);
    rst_n = 1'b1;
    step(1);
  endtask

  task automatic set_mode(logic ar, logic dm);
    mode_ar = ar; mode_do = dm;
    step(1);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 0; diag_en = 0; mode_ar = 0; mode_do = 0; ol_raw = '0;
    iset_short = 0; ext_force = 0; uv_raw = 0; tw_raw = 0; tsd_raw = 0; status_rd = 0;
    do_reset();
    chk("reset fault_ch", fault_ch, 0);
    chk("reset ch_off", ch_off, 0);
    chk("reset pull/lp", {diag_pull, lp_req, st_ol, st_iset, st_diagerr, st_tw, st_tsd, st_uv}, 0);

    // table: mode and pattern combinations (R5 R6 R7 R3 R12)
    for (int v = 0; v < NV; v++) begin
      do_reset();
      set_mode(VEC[v][51], VEC[v][50]);
      diag_en = VEC[v][49];
      ol_raw  = VEC[v][48:37];
      tk(10);
      chk("R7/R6/R5 table fault_ch", fault_ch, VEC[v][36:25]);
      chk("R7 table ch_off", ch_off, VEC[v][24:13]);
      chk("R7 table ch_low", ch_low, VEC[v][12:1]);
      chk("R6 table diag_pull", diag_pull, VEC[v][0]);
      chk("R12 table st_ol", st_ol, |VEC[v][36:25]);
    end

    // R1 / R2 filter edges
    do_reset();
    set_mode(1'b1, 1'b0);
    diag_en = 1; ol_raw = 12'h001;
    tk(9);
    chk("R1 nine ticks", fault_ch, 0);
    tk(1);
    chk("R1 tenth tick", fault_ch, 12'h001);
    ol_raw = 0;
    tk(9);
    chk("R2 clear nine ticks", fault_ch, 12'h001);
    tk(1);
    chk("R2 clear tenth tick", fault_ch, 0);
    chk("R7 resume ch_off", ch_off, 0);
    chk("R7 resume pull", diag_pull, 0);
    ol_raw = 12'h001;
    tk(5);
    ol_raw = 0;
    step(1);
    ol_raw = 12'h001;
    tk(9);
    chk("R2 reversal restart", fault_ch, 0);
    tk(1);
    chk("R1 set after restart", fault_ch, 12'h001);

    // R3 enable gating
    diag_en = 0;
    tk(12);
    chk("R3 held while enable low", fault_ch, 12'h001);
    ol_raw = 0;
    tk(12);
    chk("R3 no clear while enable low", fault_ch, 12'h001);
    diag_en = 1;
    tk(10);
    chk("R3 clears after enable", fault_ch, 0);
    diag_en = 0; ol_raw = 12'h002;
    tk(12);
    chk("R3 no set while enable low", fault_ch, 0);

    // R4 code 11 retention
    do_reset();
    set_mode(1'b1, 1'b0);
    set_mode(1'b1, 1'b1);
    diag_en = 1; ol_raw = 12'h004;
    tk(10);
    chk("R4 keep auto ch_low", ch_low, 12'h004);
    chk("R4 keep auto ch_off", ch_off, 12'hFFB);
    set_mode(1'b0, 1'b1);
    set_mode(1'b1, 1'b1);
    chk("R4 keep detect outputs", {ch_low, ch_off}, 0);
    chk("R4 keep detect pull", diag_pull, 1);

    // R6 external forcing ignored in detect-only
    do_reset();
    set_mode(1'b0, 1'b1);
    diag_en = 1; ext_force = 1;
    tk(10);
    chk("R6 ext status", st_diagerr, 1);
    chk("R6 ext no outputs", {ch_off, ch_low, lp_req}, 0);

    // R8 external forcing in auto-recovery
    do_reset();
    set_mode(1'b1, 1'b0);
    diag_en = 1; ext_force = 1;
    tk(9);
    chk("R8 ext not yet", lp_req, 0);
    tk(1);
    chk("R8 ext all off", ch_off, 12'hFFF);
    chk("R8 lp request", lp_req, 1);
    diag_en = 0;
    step(1);
    chk("R8 enable low no lp", {lp_req, ch_off}, 0);
    do_reset();
    set_mode(1'b1, 1'b0);
    diag_en = 1; ol_raw = 12'h010;
    tk(30);
    chk("R8 own pull not external", {st_diagerr, lp_req}, 0);
    chk("R8 own pull active", diag_pull, 1);

    // R9 current-set short and thermal shutdown
    do_reset();
    iset_short = 1;
    tk(10);
    chk("R9 iset status", st_iset, 1);
    chk("R9 iset all off", ch_off, 12'hFFF);
    chk("R9 iset pull", diag_pull, 1);
    do_reset();
    tsd_raw = 1;
    step(1);
    chk("R9 tsd pull", {st_tsd, diag_pull}, 2'b11);

    // R10 undervoltage
    do_reset();
    set_mode(1'b1, 1'b0);
    uv_raw = 1;
    step(1);
    chk("R10 uv flag", st_uv, 1);
    chk("R10 uv all off", ch_off, 12'hFFF);
    uv_raw = 0;
    step(1);
    chk("R10 uv release", {st_uv, ch_off}, 0);

    // R11 sticky thermal flags
    do_reset();
    tw_raw = 1;
    step(1);
    chk("R11 tw set", st_tw, 1);
    tw_raw = 0;
    step(3);
    chk("R11 tw held until read", st_tw, 1);
    status_rd = 1;
    step(1);
    status_rd = 0;
    chk("R11 tw cleared by read", st_tw, 0);
    tw_raw = 1; tsd_raw = 1;
    step(1);
    status_rd = 1;
    step(1);
    status_rd = 0;
    chk("R11 read while present keeps", {st_tw, st_tsd}, 2'b11);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule